// File: doc/BRIEF.md
# Two-Stage Candidate Elimination Set Builder

This block sits between the interval-bound calculators and the full-resolution matcher of a block motion estimator. Each candidate position in the search window is presented once per sweep. A beat carries the candidate's index together with two pairs of bounds on its true distortion: a coarse pair computed from few intensity bits and a fine pair computed from more bits. Both pairs come from the same read of the pixel data, so the surviving candidates never have to be fetched a second time.

While the sweep streams in, the block stores the bounds it still needs in a local buffer and tracks the smallest coarse upper bound. After the beat flagged as last, it scans the buffer twice. The first scan keeps every candidate whose coarse lower bound does not exceed that minimum, which gives the first survivor set. During the same scan it tracks the smallest fine upper bound among those survivors only. The second scan keeps the first-set members whose fine lower bound does not exceed the fine minimum. The resulting mask, one bit per candidate, is the window that the full-resolution stage searches. It is published with a one-cycle strobe and with the size of each set.

Top module: `mv_cand_filter`

## Requirements
- R1: A candidate is in the first set exactly when its coarse lower bound is less than or equal to the smallest coarse upper bound over all candidates of the sweep. `set1_count` reports the number of first-set members.
- R2: A lower bound equal to the relevant minimum keeps the candidate, in both stages.
- R3: The fine minimum is taken only over first-set members. A candidate outside the first set never lowers it and never appears in the final mask.
- R4: Bit i of `keep_mask` belongs to the candidate whose `in_idx` was i. The order in which the candidates arrive has no effect on the result.
- R5: `mask_valid` is high for exactly one cycle. It rises 2*NCAND clock cycles after the edge that accepts the beat with `in_last` set.
- R6: `keep_mask`, `set1_count` and `set2_count` hold their values from one `mask_valid` strobe until the next.
- R7: Beats presented between the accepted last beat and the following `mask_valid` strobe are ignored. They change neither the buffer, the minima, nor the start of a new sweep.
- R8: When every candidate has lower bound <= upper bound, the final set is non-empty. Its size never exceeds the first-set size, and `set2_count` equals the number of ones in `keep_mask`.
- R9: After reset, `mask_valid` is 0 and `keep_mask`, `set1_count` and `set2_count` are 0.
- R10: Each sweep starts with both minima at their maximum value, so the result of a sweep does not depend on earlier sweeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A candidate beat is present |
| in_last | input | 1 | This beat is the final candidate of the sweep |
| in_idx | input | IW | Candidate index, 0 to NCAND-1 |
| in_crs_lo | input | BW | Coarse lower bound |
| in_crs_hi | input | BW | Coarse upper bound |
| in_fin_lo | input | BW | Fine lower bound |
| in_fin_hi | input | BW | Fine upper bound |
| mask_valid | output | 1 | One-cycle strobe: a new result is available |
| keep_mask | output | NCAND | Final survivor mask, bit i for candidate i |
| set1_count | output | CW | Number of first-set members |
| set2_count | output | CW | Number of final-set members |

## Verification
The bench builds the block with NCAND=15 and BW=8. A candidate count that is not a power of two leaves one index code unused, so the wrap of the scan counter is tested away from a natural boundary. A stride-7 arrival order visits every index exactly once. Eight-bit bounds make exact ties with the minimum easy to construct, so keep-on-equal, the first-set restriction on the fine minimum, and the restart of the minimum between sweeps can each be forced with hand-picked values next to seeded random sweeps.

// File: rtl/mv_cand_filter_pkg.sv
package mv_cand_filter_pkg;
  typedef enum logic [1:0] {
    ST_FILL  = 2'd0,
    ST_SCAN1 = 2'd1,
    ST_SCAN2 = 2'd2
  } scan_state_e;
endpackage

// File: rtl/mv_bound_store.sv
// Holds the coarse lower bound and both fine bounds of every candidate.
module mv_bound_store #(
  parameter int NCAND = 225,
  parameter int BW    = 12,
  parameter int IW    = $clog2(NCAND)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [BW-1:0] wr_crs_lo,
  input  logic [BW-1:0] wr_fin_lo,
  input  logic [BW-1:0] wr_fin_hi,
  input  logic [IW-1:0] rd_idx,
  output logic [BW-1:0] rd_crs_lo,
  output logic [BW-1:0] rd_fin_lo,
  output logic [BW-1:0] rd_fin_hi
);
  localparam int EW = 3 * BW;
  localparam logic [IW-1:0] LAST_IDX = IW'(NCAND - 1);

  logic [EW-1:0] mem_q [NCAND];
  logic          wr_ok;
  logic [EW-1:0] rd_word;

  assign wr_ok = wr_en && (wr_idx <= LAST_IDX);

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem_q[wr_idx] <= {wr_crs_lo, wr_fin_lo, wr_fin_hi};
    end
  end

  assign rd_word   = mem_q[rd_idx];
  assign rd_crs_lo = rd_word[3*BW-1:2*BW];
  assign rd_fin_lo = rd_word[2*BW-1:BW];
  assign rd_fin_hi = rd_word[BW-1:0];
endmodule

// File: rtl/mv_min_track.sv
// Running minimum with a restart to the largest value.
module mv_min_track #(
  parameter int BW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          upd,
  input  logic [BW-1:0] val,
  output logic [BW-1:0] min_o
);
  logic [BW-1:0] min_q, min_d;
  logic          min_en;

  always_comb begin
    min_en = clr || (upd && (val < min_q));
    min_d  = clr ? {BW{1'b1}} : val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      min_q <= {BW{1'b1}};
    else if (min_en) min_q <= min_d;
  end

  assign min_o = min_q;
endmodule

// File: rtl/mv_scan_seq.sv
// Phase sequencer: fill, then two passes over the buffer.
module mv_scan_seq
  import mv_cand_filter_pkg::*;
#(
  parameter int NCAND = 225,
  parameter int IW    = $clog2(NCAND)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output scan_state_e   state_o,
  output logic [IW-1:0] idx_o,
  output logic          idx_end_o
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NCAND - 1);

  scan_state_e   state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          idx_end;

  assign idx_end = (idx_q == LAST_IDX);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    case (state_q)
      ST_FILL: begin
        if (start) begin
          state_d = ST_SCAN1;
          idx_d   = '0;
        end
      end
      ST_SCAN1: begin
        idx_d = idx_end ? '0 : idx_q + 1'b1;
        if (idx_end) state_d = ST_SCAN2;
      end
      ST_SCAN2: begin
        idx_d = idx_end ? '0 : idx_q + 1'b1;
        if (idx_end) state_d = ST_FILL;
      end
      default: begin
        state_d = ST_FILL;
        idx_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FILL;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  assign state_o   = state_q;
  assign idx_o     = idx_q;
  assign idx_end_o = idx_end;
endmodule

// File: rtl/mv_cand_filter.sv
// Two-stage survivor set builder for candidate motion vectors.
module mv_cand_filter
  import mv_cand_filter_pkg::*;
#(
  parameter int NCAND = 225,
  parameter int BW    = 12,
  parameter int IW    = $clog2(NCAND),
  parameter int CW    = $clog2(NCAND + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic [IW-1:0]    in_idx,
  input  logic [BW-1:0]    in_crs_lo,
  input  logic [BW-1:0]    in_crs_hi,
  input  logic [BW-1:0]    in_fin_lo,
  input  logic [BW-1:0]    in_fin_hi,
  output logic             mask_valid,
  output logic [NCAND-1:0] keep_mask,
  output logic [CW-1:0]    set1_count,
  output logic [CW-1:0]    set2_count
);
  // reset: asserted asynchronously, released on a clock edge
  logic rs_meta_q, rs_sync_q, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_sync_q <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_sync_q <= rs_meta_q;
    end
  end
  assign rst_int_n = rs_sync_q;

  scan_state_e   st;
  logic [IW-1:0] idx;
  logic          idx_end;
  logic          accept, start, finish;
  logic [BW-1:0] rd_crs_lo, rd_fin_lo, rd_fin_hi;
  logic [BW-1:0] min_crs, min_fin;
  logic          keep1, keep2;
  logic          in_scan1, in_scan2;

  assign accept   = in_valid && (st == ST_FILL);
  assign start    = accept && in_last;
  assign in_scan1 = (st == ST_SCAN1);
  assign in_scan2 = (st == ST_SCAN2);
  assign finish   = in_scan2 && idx_end;

  mv_scan_seq #(.NCAND(NCAND), .IW(IW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .state_o   (st),
    .idx_o     (idx),
    .idx_end_o (idx_end)
  );

  mv_bound_store #(.NCAND(NCAND), .BW(BW), .IW(IW)) u_store (
    .clk       (clk),
    .wr_en     (accept),
    .wr_idx    (in_idx),
    .wr_crs_lo (in_crs_lo),
    .wr_fin_lo (in_fin_lo),
    .wr_fin_hi (in_fin_hi),
    .rd_idx    (idx),
    .rd_crs_lo (rd_crs_lo),
    .rd_fin_lo (rd_fin_lo),
    .rd_fin_hi (rd_fin_hi)
  );

  // coarse minimum: every accepted beat, restarted when a result is published
  mv_min_track #(.BW(BW)) u_min_crs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (finish),
    .upd   (accept),
    .val   (in_crs_hi),
    .min_o (min_crs)
  );

  // fine minimum: first-set members only, restarted as the scans begin
  mv_min_track #(.BW(BW)) u_min_fin (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clr   (start),
    .upd   (in_scan1 && keep1),
    .val   (rd_fin_hi),
    .min_o (min_fin)
  );

  logic [NCAND-1:0] work_q, work_d;
  logic [CW-1:0]    cnt1_q, cnt1_d, cnt2_q, cnt2_d;
  logic [NCAND-1:0] mask_q;
  logic [CW-1:0]    oc1_q, oc2_q;
  logic             valid_q;

  assign keep1 = (rd_crs_lo <= min_crs);
  assign keep2 = work_q[idx] && (rd_fin_lo <= min_fin);

  always_comb begin
    work_d = work_q;
    cnt1_d = cnt1_q;
    cnt2_d = cnt2_q;
    if (start) begin
      cnt1_d = '0;
      cnt2_d = '0;
    end
    if (in_scan1) begin
      work_d[idx] = keep1;
      cnt1_d      = cnt1_q + CW'(keep1);
    end
    if (in_scan2) begin
      work_d[idx] = keep2;
      cnt2_d      = cnt2_q + CW'(keep2);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      work_q <= '0;
      cnt1_q <= '0;
      cnt2_q <= '0;
    end else begin
      work_q <= work_d;
      cnt1_q <= cnt1_d;
      cnt2_q <= cnt2_d;
    end
  end

  // published result, loaded only on the last step of the second scan
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      mask_q  <= '0;
      oc1_q   <= '0;
      oc2_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= finish;
      if (finish) begin
        mask_q <= work_d;
        oc1_q  <= cnt1_q;
        oc2_q  <= cnt2_d;
      end
    end
  end

  assign mask_valid = valid_q;
  assign keep_mask  = mask_q;
  assign set1_count = oc1_q;
  assign set2_count = oc2_q;
endmodule

// File: rtl/mv_cand_filter_chk.sv
module mv_cand_filter_chk #(
  parameter int NCAND = 225,
  parameter int CW    = $clog2(NCAND + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mask_valid,
  input logic [NCAND-1:0] keep_mask,
  input logic [CW-1:0]    set1_count,
  input logic [CW-1:0]    set2_count
);
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid |=> !mask_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_valid |=> ($stable(keep_mask) && $stable(set1_count) && $stable(set2_count)) || mask_valid);

  p_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid |-> (set2_count != '0));

  p_popcount_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid |-> ($countones(keep_mask) == int'(set2_count)));

  p_subset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_valid |-> (set2_count <= set1_count));
endmodule

bind mv_cand_filter mv_cand_filter_chk #(.NCAND(NCAND), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mask_valid (mask_valid),
  .keep_mask  (keep_mask),
  .set1_count (set1_count),
  .set2_count (set2_count)
);

// File: tb/sim_mv_cand_filter.sv
`timescale 1ns/1ps
module sim_mv_cand_filter;
  localparam int NC = 15;
  localparam int BW = 8;
  localparam int IW = $clog2(NC);
  localparam int CW = $clog2(NC + 1);

  typedef struct {
    logic [NC-1:0] mask;
    int            c1;
    int            c2;
    longint        due;
    string         tag;
  } exp_t;

  logic          clk, rst_n;
  logic          in_valid, in_last;
  logic [IW-1:0] in_idx;
  logic [BW-1:0] in_crs_lo, in_crs_hi, in_fin_lo, in_fin_hi;
  logic          mask_valid;
  logic [NC-1:0] keep_mask;
  logic [CW-1:0] set1_count, set2_count;

  int     errors = 0;
  int     checks = 0;
  longint cyc = 0;
  bit     done_flag = 0;
  exp_t   q[$];
  exp_t   last_exp;
  bit     have_prev = 0;

  int a_clo[NC], a_chi[NC], a_flo[NC], a_fhi[NC];

  mv_cand_filter #(.NCAND(NC), .BW(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
    .in_idx(in_idx), .in_crs_lo(in_crs_lo), .in_crs_hi(in_crs_hi),
    .in_fin_lo(in_fin_lo), .in_fin_hi(in_fin_hi), .mask_valid(mask_valid),
    .keep_mask(keep_mask), .set1_count(set1_count), .set2_count(set2_count)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // reference model, written from the requirements
  function automatic exp_t model(input string tag);
    exp_t e;
    int mc, mf;
    logic [NC-1:0] s1;
    mc = (1 << BW) - 1;
    mf = (1 << BW) - 1;
    for (int i = 0; i < NC; i++) if (a_chi[i] < mc) mc = a_chi[i];
    e.c1 = 0; e.c2 = 0; e.mask = '0; s1 = '0;
    for (int i = 0; i < NC; i++) if (a_clo[i] <= mc) begin s1[i] = 1'b1; e.c1++; end
    for (int i = 0; i < NC; i++) if (s1[i] && a_fhi[i] < mf) mf = a_fhi[i];
    for (int i = 0; i < NC; i++) if (s1[i] && a_flo[i] <= mf) begin e.mask[i] = 1'b1; e.c2++; end
    e.tag = tag;
    e.due = 0;
    return e;
  endfunction

  task automatic fill_random(input int base, input int span, input int gap);
    for (int i = 0; i < NC; i++) begin
      a_clo[i] = base + int'($urandom_range(span));
      a_chi[i] = a_clo[i] + int'($urandom_range(gap));
      a_flo[i] = base + int'($urandom_range(span));
      a_fhi[i] = a_flo[i] + int'($urandom_range(gap));
    end
  endtask

  // driver: one sweep, then the expected result goes to the scoreboard
  task automatic run_sweep(input int order, input bit junk, input string tag);
    exp_t e;
    int i;
    if (have_prev) begin
      check(keep_mask == last_exp.mask, "R6", {tag, " mask held"}, keep_mask, last_exp.mask);
      check(int'(set1_count) == last_exp.c1, "R6", {tag, " count1 held"}, set1_count, last_exp.c1);
    end
    e = model(tag);
    for (int k = 0; k < NC; k++) begin
      @(negedge clk);
      i = (order == 0) ? k : (order == 1) ? (NC - 1 - k) : ((k * 7) % NC);
      in_valid  = 1'b1;
      in_last   = (k == NC - 1);
      in_idx    = IW'(i);
      in_crs_lo = BW'(a_clo[i]);
      in_crs_hi = BW'(a_chi[i]);
      in_fin_lo = BW'(a_flo[i]);
      in_fin_hi = BW'(a_fhi[i]);
    end
    @(negedge clk);
    e.due = cyc + 2 * NC;
    q.push_back(e);
    in_valid = 1'b0;
    in_last  = 1'b0;
    if (junk) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        in_valid  = 1'b1;
        in_last   = (k % 2 == 0);
        in_idx    = IW'(k);
        in_crs_lo = '0; in_crs_hi = '0; in_fin_lo = '0; in_fin_hi = '0;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    last_exp  = e;
    have_prev = 1;
    repeat (12) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on every result strobe
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (mask_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R5", "unexpected strobe", 1, 0);
        end else begin
          e = q.pop_front();
          check(cyc == e.due, "R5", {e.tag, " strobe cycle"}, cyc, e.due);
          check(keep_mask == e.mask, "R3/R4", {e.tag, " final mask"}, keep_mask, e.mask);
          check(int'(set1_count) == e.c1, "R1", {e.tag, " first-set size"}, set1_count, e.c1);
          check(int'(set2_count) == e.c2, "R8", {e.tag, " final-set size"}, set2_count, e.c2);
          @(negedge clk);
          check(!mask_valid, "R5", {e.tag, " strobe width"}, mask_valid, 0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", "run did not finish", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0; in_last = 1'b0; in_idx = '0;
    in_crs_lo = '0; in_crs_hi = '0; in_fin_lo = '0; in_fin_hi = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9: reset state
    check(mask_valid == 1'b0, "R9", "strobe after reset", mask_valid, 0);
    check(keep_mask == '0, "R9", "mask after reset", keep_mask, 0);
    check(set1_count == '0, "R9", "count1 after reset", set1_count, 0);
    check(set2_count == '0, "R9", "count2 after reset", set2_count, 0);

    // all bounds equal: every candidate survives both stages
    for (int i = 0; i < NC; i++) begin a_clo[i] = 50; a_chi[i] = 50; a_flo[i] = 50; a_fhi[i] = 50; end
    run_sweep(0, 0, "R1 all-equal");

    // seeded random bounds, ascending order
    fill_random(0, 200, 40);
    run_sweep(0, 0, "R1 random");

    // R2 ties kept; R3 a non-member with a tiny fine upper bound
    for (int i = 0; i < NC; i++) begin a_clo[i] = 100; a_chi[i] = 150; a_flo[i] = 0; a_fhi[i] = 200; end
    a_clo[3] = 80;  a_chi[3] = 90;  a_flo[3] = 60; a_fhi[3] = 70;
    a_clo[5] = 90;  a_chi[5] = 150; a_flo[5] = 70; a_fhi[5] = 120;
    a_clo[6] = 91;  a_chi[6] = 150;
    a_clo[7] = 100; a_chi[7] = 150; a_flo[7] = 5;  a_fhi[7] = 10;
    run_sweep(0, 0, "R2 ties");

    // R4: reversed and stride-7 arrival orders
    fill_random(10, 150, 60);
    run_sweep(1, 0, "R4 reversed");
    fill_random(0, 230, 20);
    run_sweep(2, 0, "R4 strided");

    // R7: junk beats while the scans run
    fill_random(20, 120, 30);
    run_sweep(0, 1, "R7 junk");

    // R10: every bound above the previous minima
    fill_random(160, 60, 30);
    run_sweep(2, 0, "R10 restart");

    check(keep_mask == last_exp.mask, "R6", "final mask held", keep_mask, last_exp.mask);
    finish_run();
  end
endmodule